// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block is the control engine of one DMA channel. It is handed the address of a list of 8-byte descriptors in memory. It reads them one at a time through a simple request/response read port. For each descriptor that asks for a transfer, it gives the data mover one command carrying a buffer address and a byte length. It then waits for the mover's completion pulse. When a descriptor flagged as final has been handled, the walk ends with a one-cycle done pulse.

The channel works in one of two directions, chosen by `rx_mode`. In transmit mode, writing the list address starts the walk at once from that address. In receive mode, the list address is only stored, and the walk starts when the enable control is written to 1. Writing enable to 0 stops a receive walk at any point. A descriptor that is malformed stops the walk with an error pulse, and no command is issued for it. The high half of the list address is always zero, so only a 32-bit pointer is kept. Moving the data and formatting video rows are not part of this block.

Top module: `sgw_walker`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `err`, `rd_req_valid` and `cmd_valid` are all 0.
- R2: Descriptor byte k arrives on `rd_rsp_data[8k+7:8k]`. In byte 0, bit 0 means valid, bit 1 means final and bit 5 means transfer. Bytes 2..3 hold the length, low byte first. Bytes 4..7 hold the buffer address, low byte first. Byte 1 and the other flag bits are ignored.
- R3: The first fetch uses the start address, and each later fetch uses the previous address plus 8. `rd_req_valid` and `rd_req_addr` stay steady until `rd_req_ready` is seen.
- R4: Each valid descriptor with the transfer bit set produces exactly one command, whose `cmd_addr` and `cmd_len` are taken from the descriptor. The command stays steady until `cmd_ready` is seen.
- R5: A valid descriptor with the transfer bit clear produces no command. The walk goes on to the next descriptor, or ends if this one is final.
- R6: The next descriptor is fetched only after the current command's `mv_done` pulse. A read request and a command are never pending at the same time.
- R7: After the final descriptor has been handled, `done` pulses for one cycle and `busy` is low in that same cycle.
- R8: A descriptor that is not valid, or whose length is zero or not a multiple of 4, produces an `err` pulse and no command. The walk then ends without `done`.
- R9: In transmit mode (`rx_mode`=0), a write of `cfg_addr` while idle starts a walk at that address.
- R10: In receive mode, a write of `cfg_addr` only stores the address. A later enable write of 1 starts the walk from the stored address.
- R11: In receive mode, an enable write of 0 while busy sends the block to idle in the next cycle. No `done` follows, and no further fetch or command is issued.
- R12: While busy, a start request is ignored, and a `cfg_addr` write neither redirects the walk nor changes the stored address.
- R13: `busy` rises only on an accepted start. It stays high until done, error or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1 = receive start rules, 0 = transmit; change only while idle |
| cfg_addr_wr | input | 1 | Write strobe for the list address |
| cfg_addr | input | 32 | List address, low word |
| cfg_en_wr | input | 1 | Write strobe for the receive enable |
| cfg_en | input | 1 | Enable value written |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_addr | output | 32 | Descriptor address |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Descriptor data valid |
| rd_rsp_data | input | 64 | Descriptor bytes, byte 0 in the low bits |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_addr | output | 32 | Buffer address of the command |
| cmd_len | output | 16 | Byte length of the command |
| cmd_ready | input | 1 | Command accepted by the mover |
| mv_done | input | 1 | Mover completion pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the list is complete |
| err | output | 1 | One-cycle pulse when a bad descriptor ends the walk |

## Verification
Random lists of one to eight descriptors are walked. They have random lengths and addresses and a mix of transfer and skip descriptors, and the memory and mover stall at random. This separates correct address stepping and field unpacking from errors in byte order or pointer increment. Directed lists then corrupt one descriptor by clearing its valid bit, zeroing its length or making its length unaligned, each at different positions, to show that the error path cuts the walk at exactly that descriptor. Further cases cover a single-descriptor list, the largest aligned length and a skip-only list. Receive-mode runs set the enable-driven start, the address-only write, a mid-walk abort and writes made while busy against the transmit start rule.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int BUF_AW     = 32;
  localparam int XLEN_W     = 16;
  localparam int FLG_VALID  = 0;
  localparam int FLG_LAST   = 1;
  localparam int FLG_XFER   = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT_RSP, S_CHECK, S_ISSUE, S_WAIT_MV
  } walk_state_t;

  typedef struct packed {
    logic              valid;
    logic              last;
    logic              xfer;
    logic [XLEN_W-1:0] len;
    logic [BUF_AW-1:0] buf_addr;
  } desc_t;

  // length must be non-zero and a multiple of 2**align_lg2
  function automatic logic len_ok(input logic [XLEN_W-1:0] len,
                                  input int unsigned align_lg2);
    logic [XLEN_W-1:0] mask;
    mask = XLEN_W'((32'd1 << align_lg2) - 32'd1);
    return (len != '0) && ((len & mask) == '0);
  endfunction

  // pointer to the descriptor that follows
  function automatic logic [BUF_AW-1:0] step_ptr(input logic [BUF_AW-1:0] p);
    return p + BUF_AW'(DESC_BYTES);
  endfunction
endpackage

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int ALIGN_LG2 = 2
) (
  input  logic [DESC_W-1:0] raw,
  output desc_t             dsc,
  output logic              ok
);
  logic [7:0] byte_q [DESC_BYTES];

  for (genvar gi = 0; gi < DESC_BYTES; gi++) begin : g_bytes
    assign byte_q[gi] = raw[8*gi +: 8];
  end

  assign dsc.valid    = byte_q[0][FLG_VALID];
  assign dsc.last     = byte_q[0][FLG_LAST];
  assign dsc.xfer     = byte_q[0][FLG_XFER];
  assign dsc.len      = {byte_q[3], byte_q[2]};
  assign dsc.buf_addr = {byte_q[7], byte_q[6], byte_q[5], byte_q[4]};
  assign ok           = dsc.valid && len_ok(dsc.len, ALIGN_LG2);
endmodule

// File: rtl/sgw_start.sv
module sgw_start
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              cfg_addr_wr,
  input  logic [BUF_AW-1:0] cfg_addr,
  input  logic              cfg_en_wr,
  input  logic              cfg_en,
  input  logic              busy,
  output logic              start_evt,
  output logic              abort_evt,
  output logic [BUF_AW-1:0] start_ptr
);
  logic [BUF_AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     base_q <= '0;
    else if (cfg_addr_wr && !busy)  base_q <= cfg_addr;
  end

  assign start_evt = !busy && (rx_mode ? (cfg_en_wr && cfg_en) : cfg_addr_wr);
  assign abort_evt = busy && rx_mode && cfg_en_wr && !cfg_en;
  assign start_ptr = rx_mode ? base_q : cfg_addr;
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              abort_evt,
  input  logic [BUF_AW-1:0] start_ptr,
  output logic              rd_req_valid,
  output logic [BUF_AW-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DESC_W-1:0] rd_rsp_data,
  output logic [DESC_W-1:0] raw_q,
  input  logic              d_ok,
  input  logic              d_xfer,
  input  logic              d_last,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic              mv_done,
  output logic              busy,
  output logic              done,
  output logic              err
);
  walk_state_t       state_q;
  logic [BUF_AW-1:0] ptr_q;
  logic              done_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      raw_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort_evt) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_evt) begin
            ptr_q   <= start_ptr;
            state_q <= S_FETCH;
          end
          S_FETCH: if (rd_req_ready) state_q <= S_WAIT_RSP;
          S_WAIT_RSP: if (rd_rsp_valid) begin
            raw_q   <= rd_rsp_data;
            state_q <= S_CHECK;
          end
          S_CHECK: begin
            if (!d_ok) begin
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end else if (d_xfer) begin
              state_q <= S_ISSUE;
            end else if (d_last) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              ptr_q   <= step_ptr(ptr_q);
              state_q <= S_FETCH;
            end
          end
          S_ISSUE: if (cmd_ready) state_q <= S_WAIT_MV;
          S_WAIT_MV: if (mv_done) begin
            if (d_last) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              ptr_q   <= step_ptr(ptr_q);
              state_q <= S_FETCH;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign rd_req_valid = (state_q == S_FETCH);
  assign rd_req_addr  = ptr_q;
  assign cmd_valid    = (state_q == S_ISSUE);
  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int ALIGN_LG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              cfg_addr_wr,
  input  logic [BUF_AW-1:0] cfg_addr,
  input  logic              cfg_en_wr,
  input  logic              cfg_en,
  output logic              rd_req_valid,
  output logic [BUF_AW-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DESC_W-1:0] rd_rsp_data,
  output logic              cmd_valid,
  output logic [BUF_AW-1:0] cmd_addr,
  output logic [XLEN_W-1:0] cmd_len,
  input  logic              cmd_ready,
  input  logic              mv_done,
  output logic              busy,
  output logic              done,
  output logic              err
);
  // named internal events, also observed by the checker
  logic              start_evt;
  logic              abort_evt;
  logic [BUF_AW-1:0] start_ptr;
  logic [DESC_W-1:0] raw_q;
  desc_t             dsc;
  logic              desc_ok;

  sgw_start u_start (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .cfg_addr_wr(cfg_addr_wr), .cfg_addr(cfg_addr),
    .cfg_en_wr(cfg_en_wr), .cfg_en(cfg_en), .busy(busy),
    .start_evt(start_evt), .abort_evt(abort_evt), .start_ptr(start_ptr)
  );

  sgw_decode #(.ALIGN_LG2(ALIGN_LG2)) u_decode (
    .raw(raw_q), .dsc(dsc), .ok(desc_ok)
  );

  sgw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .abort_evt(abort_evt), .start_ptr(start_ptr),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .raw_q(raw_q),
    .d_ok(desc_ok), .d_xfer(dsc.xfer), .d_last(dsc.last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .mv_done(mv_done),
    .busy(busy), .done(done), .err(err)
  );

  assign cmd_addr = dsc.buf_addr;
  assign cmd_len  = dsc.len;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_addr,
  input logic [15:0] cmd_len,
  input logic        start_evt,
  input logic        abort_evt,
  input logic        desc_ok
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !abort_evt |=> rd_req_valid && $stable(rd_req_addr));
  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !abort_evt |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));
  // R6
  one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && cmd_valid));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8
  cmd_good_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> desc_ok);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy && !done && !err);
  // R13
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt));
endmodule

bind sgw_walker sgw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .start_evt(start_evt), .abort_evt(abort_evt), .desc_ok(desc_ok)
);

// File: tb/sgw_walker_tb.sv
module sgw_walker_tb;
  logic        clk = 0, rst_n = 0;
  logic        rx_mode = 0, cfg_addr_wr = 0, cfg_en_wr = 0, cfg_en = 0;
  logic [31:0] cfg_addr = 0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr;
  logic [63:0] rd_rsp_data;
  logic        cmd_valid, cmd_ready, mv_done;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic        busy, done, err;

  sgw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .cfg_addr_wr(cfg_addr_wr), .cfg_addr(cfg_addr),
    .cfg_en_wr(cfg_en_wr), .cfg_en(cfg_en),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .mv_done(mv_done),
    .busy(busy), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  logic [63:0] mem [64];
  int n_chk = 0, n_err = 0;
  int f_n, c_n, done_n, err_n;
  logic [31:0] f_log [64];
  logic [31:0] ca_log [64];
  logic [15:0] cl_log [64];
  int e_f, e_c, e_done, e_err;
  logic [31:0] e_fetch [64];
  logic [31:0] e_ca [64];
  logic [15:0] e_cl [64];
  int rsp_t = 0, mv_t = 0;
  logic [5:0] rsp_idx;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic v, input logic x, input logic l,
                                     input logic [15:0] len, input logic [31:0] a);
    logic [7:0] fl;
    fl = 8'h00;
    fl[0] = v; fl[1] = l; fl[5] = x;
    return {a[31:24], a[23:16], a[15:8], a[7:0], len[15:8], len[7:0], 8'hA5, fl};
  endfunction

  // bench-side model of a walk (R2, R3, R5, R7, R8)
  task automatic model(input logic [31:0] start);
    logic [31:0] p;
    logic [63:0] d;
    p = start; e_f = 0; e_c = 0; e_done = 0; e_err = 0;
    for (int k = 0; k < 64; k++) begin
      e_fetch[e_f] = p; e_f++;
      d = mem[p[8:3]];
      if (!d[0] || d[31:16] == 0 || d[17:16] != 2'b00) begin e_err = 1; break; end
      if (d[5]) begin e_ca[e_c] = d[63:32]; e_cl[e_c] = d[31:16]; e_c++; end
      if (d[1]) begin e_done = 1; break; end
      p = p + 8;
    end
  endtask

  task automatic gen_list(input logic [31:0] start, input int n, input int skip_pct);
    for (int k = 0; k < n; k++) begin
      logic [15:0] len;
      len = 16'(4 * (1 + ($urandom % 256)));
      mem[start[8:3] + 6'(k)] = mk(1'b1, ($urandom % 100) >= skip_pct, k == n - 1,
                                   len, $urandom);
    end
  endtask

  task automatic clear_logs();
    f_n = 0; c_n = 0; done_n = 0; err_n = 0;
  endtask

  task automatic wait_end(input string req);
    int t;
    t = 0;
    while (done_n + err_n == 0 && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, {req, " walk ended"}, t, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(f_n == e_f, {req, " fetch count"}, f_n, e_f);
    for (int i = 0; i < e_f && i < f_n; i++)
      chk(f_log[i] == e_fetch[i], {req, " fetch addr R3"}, f_log[i], e_fetch[i]);
    chk(c_n == e_c, {req, " cmd count R4"}, c_n, e_c);
    for (int i = 0; i < e_c && i < c_n; i++) begin
      chk(ca_log[i] == e_ca[i], {req, " cmd addr R2"}, ca_log[i], e_ca[i]);
      chk(cl_log[i] == e_cl[i], {req, " cmd len R2"}, cl_log[i], e_cl[i]);
    end
    chk(done_n == e_done, {req, " done R7"}, done_n, e_done);
    chk(err_n == e_err, {req, " err R8"}, err_n, e_err);
    chk(busy == 1'b0, {req, " busy low R13"}, busy, 0);
  endtask

  task automatic start_tx(input logic [31:0] a);
    @(negedge clk); cfg_addr = a; cfg_addr_wr = 1;
    @(negedge clk); cfg_addr_wr = 0;
    chk(busy == 1'b1, "R13 R9 busy after start", busy, 1);
  endtask

  task automatic write_en(input logic v);
    @(negedge clk); cfg_en = v; cfg_en_wr = 1;
    @(negedge clk); cfg_en_wr = 0;
  endtask

  task automatic run_tx(input logic [31:0] a, input string req);
    clear_logs(); model(a); start_tx(a); wait_end(req); compare(req);
  endtask

  // memory responder
  initial begin
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 0;
      if (rsp_t > 0) begin
        rsp_t--;
        if (rsp_t == 0) begin rd_rsp_valid = 1; rd_rsp_data = mem[rsp_idx]; end
      end
      rd_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        if (f_n < 64) f_log[f_n] = rd_req_addr;
        f_n++;
        rsp_idx = rd_req_addr[8:3];
        rsp_t = 1 + ($urandom % 3);
      end
    end
  end

  // data mover model
  initial begin
    cmd_ready = 0; mv_done = 0;
    forever begin
      @(negedge clk);
      mv_done = 0;
      if (mv_t > 0) begin mv_t--; if (mv_t == 0) mv_done = 1; end
      cmd_ready = ($urandom % 2) != 0;
      if (cmd_valid && cmd_ready) begin
        if (c_n < 64) begin ca_log[c_n] = cmd_addr; cl_log[c_n] = cmd_len; end
        c_n++;
        mv_t = 1 + ($urandom % 4);
      end
    end
  end

  // pulse monitor
  initial forever begin
    @(negedge clk);
    if (done) done_n++;
    if (err) err_n++;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int fs, cs;
    logic [31:0] st, other;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !rd_req_valid && !cmd_valid, "R1 reset outputs",
        {busy, done, err, rd_req_valid, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_req_valid && !cmd_valid, "R1 after reset", {busy, rd_req_valid, cmd_valid}, 0);

    // R9 single final descriptor, smallest and largest aligned lengths
    mem[2] = mk(1, 1, 1, 16'd4, 32'h1234_5678);
    run_tx(32'h10, "R9 R2 single len4");
    mem[2] = mk(1, 1, 1, 16'hFFFC, 32'hDEAD_BEEF);
    run_tx(32'h10, "R2 max len");

    // R5 skip-only list
    mem[4] = mk(1, 0, 0, 16'd8, 32'h1);
    mem[5] = mk(1, 0, 1, 16'd8, 32'h2);
    run_tx(32'h20, "R5 skip only");

    // random lists with stalls (R3 R4 R5 R6)
    for (int t = 0; t < 24; t++) begin
      st = 32'(8 * ($urandom % 32));
      gen_list(st, 1 + ($urandom % 8), 25);
      run_tx(st, "R4 R6 random list");
    end

    // R8 error cases at various positions
    for (int kind = 0; kind < 3; kind++) begin
      for (int pos = 0; pos < 3; pos++) begin
        int j;
        st = 32'(8 * ($urandom % 24));
        gen_list(st, 5, 0);
        j = st[8:3] + pos + kind;
        if (kind == 0) mem[j][0] = 1'b0;
        else if (kind == 1) mem[j][31:16] = 16'd0;
        else mem[j][17:16] = 2'b10;
        run_tx(st, "R8 bad descriptor");
      end
    end

    // R12 TX: address write while busy is ignored
    gen_list(32'h40, 6, 0);
    clear_logs(); model(32'h40); start_tx(32'h40);
    while (f_n < 2 && done_n == 0) @(negedge clk);
    @(negedge clk); cfg_addr = 32'h100; cfg_addr_wr = 1;
    @(negedge clk); cfg_addr_wr = 0;
    wait_end("R12 tx"); compare("R12 tx");

    // R10 receive mode: address write only stores
    rx_mode = 1;
    st = 32'h60;
    gen_list(st, 4, 20);
    clear_logs();
    @(negedge clk); cfg_addr = st; cfg_addr_wr = 1;
    @(negedge clk); cfg_addr_wr = 0;
    repeat (6) @(negedge clk);
    chk(busy == 0 && f_n == 0, "R10 address write no start", f_n, 0);
    model(st);
    write_en(1);
    chk(busy == 1'b1, "R10 R13 enable starts", busy, 1);
    // R12 while busy: new address is not stored, enable=1 again ignored
    @(negedge clk); cfg_addr = 32'h140; cfg_addr_wr = 1;
    @(negedge clk); cfg_addr_wr = 0;
    write_en(1);
    wait_end("R10 rx"); compare("R10 rx");
    clear_logs(); model(st);
    write_en(1);
    wait_end("R12 rx stored addr"); compare("R12 rx stored addr");

    // R11 abort mid-walk
    for (int t = 0; t < 3; t++) begin
      st = 32'(8 * ($urandom % 16));
      gen_list(st, 8, 0);
      @(negedge clk); cfg_addr = st; cfg_addr_wr = 1;
      @(negedge clk); cfg_addr_wr = 0;
      clear_logs();
      write_en(1);
      while (c_n < 1 + t && done_n == 0) @(negedge clk);
      write_en(0);
      chk(busy == 1'b0, "R11 idle after abort", busy, 0);
      fs = f_n; cs = c_n;
      repeat (30) @(negedge clk);
      chk(f_n == fs, "R11 no fetch after abort", f_n, fs);
      chk(c_n == cs, "R11 no cmd after abort", c_n, cs);
      chk(done_n == 0, "R11 no done after abort", done_n, 0);
      chk(busy == 1'b0, "R11 stays idle", busy, 0);
    end

    // R9 back to transmit after receive use
    rx_mode = 0;
    other = 32'h80;
    gen_list(other, 3, 30);
    run_tx(other, "R9 tx again");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule